// File: doc/BRIEF.md
# DMA Interrupt Pending Dispatcher

This block sits beside a multi-channel DMA engine. For each channel it keeps a transfer-complete flag and a transfer-error flag, and for each flag an enable bit. The engine raises the flags with single-cycle pulses. The block drives one interrupt line and one pending register. That register names a single channel and shows that channel's flags. Software reads the pending register and services the channel it names. It then writes the same value back, which acknowledges that channel alone. Any other channel that is still pending keeps the interrupt asserted, so it shows up on the next read.

Software reaches the per-channel registers through a channel-select field and one write strobe per register. The enable-set register turns enables on. The enable-clear register turns them off. The flag register clears flags where ones are written. In every 2-bit write field, bit 0 stands for complete and bit 1 for error. The pending register is laid out as `{channel_id, err, cmpl}`: bit 0 is complete, bit 1 is error, and bits [ID_W+1:2] hold the channel ID. ID_W is the number of bits needed to encode every channel.

Top module: `ipd_dispatch`

## Requirements
- R1: While reset is high, and one clock after it is released, every flag and enable is 0, `irq_o` is 0 and `pend_o` is 0.
- R2: An `evt_cmpl_i[c]` pulse sets the complete flag of channel c, and an `evt_err_i[c]` pulse sets its error flag. The flag is visible on `flag_cmpl_o`/`flag_err_o` at the first clock edge after the pulse.
- R3: A write through `ien_set_we_i` sets the enables of channel `cfg_ch_i` wherever `cfg_wdata_i` holds a one (bit 0 complete, bit 1 error). A zero bit leaves that enable unchanged.
- R4: A write through `ien_clr_we_i` clears the enables of channel `cfg_ch_i` wherever `cfg_wdata_i` holds a one, and a zero bit leaves that enable unchanged. If the enable-set and enable-clear strobes arrive in the same cycle, the set wins.
- R5: A write through `flag_clr_we_i` clears the flags of channel `cfg_ch_i` wherever `cfg_wdata_i` holds a one (write-one-to-clear).
- R6: If an engine event and a software clear of the same flag land in the same cycle, the flag ends up set.
- R7: `irq_o` is the OR over all channels of (flag AND enable), registered one cycle after the flags and enables.
- R8: `pend_o` reports the lowest-numbered channel that has an enabled flag set. Its ID goes in bits [ID_W+1:2], and its raw error and complete flags go in bits 1 and 0. `pend_o` is 0 whenever no such channel exists.
- R9: A write through `pend_we_i` clears, for the channel named in bits [ID_W+1:2] of `pend_wdata_i` only, the flags whose bits (bit 1 error, bit 0 complete) are one. Other channels are untouched, and `irq_o` stays high while any other enabled flag remains.
- R10: A channel whose set flags are all disabled is never reported in `pend_o` and does not assert `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_cmpl_i | input | NCH | Transfer-complete event pulses from the engine, one per channel |
| evt_err_i | input | NCH | Transfer-error event pulses from the engine, one per channel |
| cfg_ch_i | input | ID_W | Channel selected for per-channel register writes |
| cfg_wdata_i | input | 2 | Per-channel write data: bit 0 complete, bit 1 error |
| ien_set_we_i | input | 1 | Write strobe for the enable-set register |
| ien_clr_we_i | input | 1 | Write strobe for the enable-clear register |
| flag_clr_we_i | input | 1 | Write strobe for the write-one-to-clear flag register |
| pend_we_i | input | 1 | Write strobe for the pending register (acknowledge) |
| pend_wdata_i | input | ID_W+2 | Acknowledge value `{channel_id, err, cmpl}` |
| pend_o | output | ID_W+2 | Pending register `{channel_id, err, cmpl}` |
| irq_o | output | 1 | Interrupt request |
| flag_cmpl_o | output | NCH | Complete flags of all channels |
| flag_err_o | output | NCH | Error flags of all channels |
| ien_cmpl_o | output | NCH | Complete enables of all channels |
| ien_err_o | output | NCH | Error enables of all channels |

## Verification
The bench raises flags on channels whose enables are off. A dispatcher that ignored the enables would then report those channels or raise the interrupt. It acknowledges with a wrong ID and with an all-zero flag field. A design with sloppy ID decoding would clear the wrong channel or clear everything. It lands a flag event and a software clear in the same cycle. Giving the clear priority would lose the event and drop the interrupt. It also leaves two channels pending and acknowledges the lower one. A dispatcher that got the priority order wrong, or that cleared globally, would then report the wrong channel or release the line too early.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
  // bit positions inside the 2-bit per-channel fields and the pending register
  localparam int unsigned PB_CMPL = 0;
  localparam int unsigned PB_ERR  = 1;

  function automatic int unsigned id_width(input int unsigned nch);
    return (nch > 1) ? $clog2(nch) : 1;
  endfunction
endpackage

// File: rtl/ipd_flag_bank.sv
module ipd_flag_bank #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_cmpl_i,
  input  logic [NCH-1:0] set_err_i,
  input  logic [NCH-1:0] clr_cmpl_i,
  input  logic [NCH-1:0] clr_err_i,
  input  logic [NCH-1:0] ens_cmpl_i,
  input  logic [NCH-1:0] ens_err_i,
  input  logic [NCH-1:0] enc_cmpl_i,
  input  logic [NCH-1:0] enc_err_i,
  output logic [NCH-1:0] flag_cmpl_o,
  output logic [NCH-1:0] flag_err_o,
  output logic [NCH-1:0] en_cmpl_o,
  output logic [NCH-1:0] en_err_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_cmpl_o[c] <= 1'b0;
        flag_err_o[c]  <= 1'b0;
        en_cmpl_o[c]   <= 1'b0;
        en_err_o[c]    <= 1'b0;
      end else begin
        // engine set dominates software clear
        flag_cmpl_o[c] <= (flag_cmpl_o[c] & ~clr_cmpl_i[c]) | set_cmpl_i[c];
        flag_err_o[c]  <= (flag_err_o[c]  & ~clr_err_i[c])  | set_err_i[c];
        en_cmpl_o[c]   <= (en_cmpl_o[c] & ~enc_cmpl_i[c]) | ens_cmpl_i[c];
        en_err_o[c]    <= (en_err_o[c]  & ~enc_err_i[c])  | ens_err_i[c];
      end
    end

    // R6 / R2: a set event always leaves the flag high
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      set_cmpl_i[c] |=> flag_cmpl_o[c]);
    p_err_set_r2: assert property (@(posedge clk) disable iff (rst)
      set_err_i[c] |=> flag_err_o[c]);
    // R9 / R5: a clear without a competing set drops the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (clr_cmpl_i[c] && !set_cmpl_i[c]) |=> !flag_cmpl_o[c]);
    // R4: enable clear without a set drops the enable
    p_en_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (enc_err_i[c] && !ens_err_i[c]) |=> !en_err_o[c]);
  end
endmodule

// File: rtl/ipd_pick.sv
module ipd_pick #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned ID_W = 3
) (
  input  logic [NCH-1:0]  flag_cmpl_i,
  input  logic [NCH-1:0]  flag_err_i,
  input  logic [NCH-1:0]  en_cmpl_i,
  input  logic [NCH-1:0]  en_err_i,
  output logic            any_o,
  output logic [ID_W+1:0] pend_o
);
  logic [NCH-1:0] live;
  assign live  = (flag_cmpl_i & en_cmpl_i) | (flag_err_i & en_err_i);
  assign any_o = |live;

  // scan from the top so the lowest live channel is the last to win
  always_comb begin
    pend_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (live[i]) begin
        pend_o = {ID_W'(i), flag_err_i[i], flag_cmpl_i[i]};
      end
    end
  end
endmodule

// File: rtl/ipd_dispatch.sv
module ipd_dispatch #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned ID_W = ipd_pkg::id_width(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  evt_cmpl_i,
  input  logic [NCH-1:0]  evt_err_i,
  input  logic [ID_W-1:0] cfg_ch_i,
  input  logic [1:0]      cfg_wdata_i,
  input  logic            ien_set_we_i,
  input  logic            ien_clr_we_i,
  input  logic            flag_clr_we_i,
  input  logic            pend_we_i,
  input  logic [ID_W+1:0] pend_wdata_i,
  output logic [ID_W+1:0] pend_o,
  output logic            irq_o,
  output logic [NCH-1:0]  flag_cmpl_o,
  output logic [NCH-1:0]  flag_err_o,
  output logic [NCH-1:0]  ien_cmpl_o,
  output logic [NCH-1:0]  ien_err_o
);
  import ipd_pkg::*;

  logic [NCH-1:0] clr_cmpl, clr_err, ens_cmpl, ens_err, enc_cmpl, enc_err;

  // per-channel decode of the software strobes
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic cfg_hit, ack_hit;
    assign cfg_hit = (cfg_ch_i == ID_W'(c));
    assign ack_hit = pend_we_i && (pend_wdata_i[ID_W+1:2] == ID_W'(c));
    assign clr_cmpl[c] = (flag_clr_we_i && cfg_hit && cfg_wdata_i[PB_CMPL])
                       | (ack_hit && pend_wdata_i[PB_CMPL]);
    assign clr_err[c]  = (flag_clr_we_i && cfg_hit && cfg_wdata_i[PB_ERR])
                       | (ack_hit && pend_wdata_i[PB_ERR]);
    assign ens_cmpl[c] = ien_set_we_i && cfg_hit && cfg_wdata_i[PB_CMPL];
    assign ens_err[c]  = ien_set_we_i && cfg_hit && cfg_wdata_i[PB_ERR];
    assign enc_cmpl[c] = ien_clr_we_i && cfg_hit && cfg_wdata_i[PB_CMPL];
    assign enc_err[c]  = ien_clr_we_i && cfg_hit && cfg_wdata_i[PB_ERR];
  end

  ipd_flag_bank #(.NCH(NCH)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .set_cmpl_i  (evt_cmpl_i),
    .set_err_i   (evt_err_i),
    .clr_cmpl_i  (clr_cmpl),
    .clr_err_i   (clr_err),
    .ens_cmpl_i  (ens_cmpl),
    .ens_err_i   (ens_err),
    .enc_cmpl_i  (enc_cmpl),
    .enc_err_i   (enc_err),
    .flag_cmpl_o (flag_cmpl_o),
    .flag_err_o  (flag_err_o),
    .en_cmpl_o   (ien_cmpl_o),
    .en_err_o    (ien_err_o)
  );

  logic            any_d;
  logic [ID_W+1:0] pend_d;

  ipd_pick #(.NCH(NCH), .ID_W(ID_W)) u_pick (
    .flag_cmpl_i (flag_cmpl_o),
    .flag_err_i  (flag_err_o),
    .en_cmpl_i   (ien_cmpl_o),
    .en_err_i    (ien_err_o),
    .any_o       (any_d),
    .pend_o      (pend_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      pend_o <= '0;
    end else begin
      irq_o  <= any_d;
      pend_o <= pend_d;
    end
  end

  // R1: outputs are quiet one cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_o && pend_o == '0));
  // R8: an asserted line always comes with a flag in the pending register
  p_pend_has_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pend_o[1:0] != 2'b00));
  // R8: no interrupt means an empty pending register
  p_pend_empty_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (pend_o == '0));
  // R7: a new enabled flag raises the line on the next cycle
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(|(flag_err_o & ien_err_o)) |=> irq_o);
endmodule

// File: tb/sim_ipd_dispatch.sv
module sim_ipd_dispatch;
  localparam int unsigned NCH  = 8;
  localparam int unsigned ID_W = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH-1:0]  evt_cmpl = '0, evt_err = '0;
  logic [ID_W-1:0] cfg_ch = '0;
  logic [1:0]      cfg_wdata = '0;
  logic            ien_set_we = 1'b0, ien_clr_we = 1'b0, flag_clr_we = 1'b0, pend_we = 1'b0;
  logic [ID_W+1:0] pend_wdata = '0;
  logic [ID_W+1:0] pend;
  logic            irq;
  logic [NCH-1:0]  fl_c, fl_e, en_c, en_e;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  ipd_dispatch #(.NCH(NCH)) u0 (
    .clk(clk), .rst(rst), .evt_cmpl_i(evt_cmpl), .evt_err_i(evt_err),
    .cfg_ch_i(cfg_ch), .cfg_wdata_i(cfg_wdata), .ien_set_we_i(ien_set_we),
    .ien_clr_we_i(ien_clr_we), .flag_clr_we_i(flag_clr_we), .pend_we_i(pend_we),
    .pend_wdata_i(pend_wdata), .pend_o(pend), .irq_o(irq),
    .flag_cmpl_o(fl_c), .flag_err_o(fl_e), .ien_cmpl_o(en_c), .ien_err_o(en_e)
  );

  // op codes: 0 complete event, 1 error event, 2 enable set, 3 enable clear,
  // 4 flag W1C, 5 pending write, 6 complete event plus W1C of complete
  // vector = {op[2:0], ch[2:0], data[4:0], exp_irq, exp_pend[4:0]}
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {3'd0, 3'd5, 5'd0,  1'b0, 5'd0 },  // R10 flag without enable
    {3'd2, 3'd5, 5'd1,  1'b1, 5'd21},  // R3 R8
    {3'd1, 3'd2, 5'd0,  1'b1, 5'd21},  // R10
    {3'd2, 3'd2, 5'd2,  1'b1, 5'd10},  // R8 lowest channel
    {3'd0, 3'd2, 5'd0,  1'b1, 5'd11},  // R8 raw flags
    {3'd5, 3'd0, 5'd10, 1'b1, 5'd21},  // R9 clear err of ch2 only
    {3'd5, 3'd0, 5'd21, 1'b0, 5'd0 },  // R9 R10
    {3'd2, 3'd2, 5'd1,  1'b1, 5'd9 },  // R3
    {3'd3, 3'd2, 5'd2,  1'b1, 5'd9 },  // R4 zero bit no effect
    {3'd3, 3'd2, 5'd1,  1'b0, 5'd0 },  // R4
    {3'd2, 3'd2, 5'd1,  1'b1, 5'd9 },  // R3
    {3'd4, 3'd2, 5'd1,  1'b0, 5'd0 },  // R5
    {3'd6, 3'd2, 5'd1,  1'b1, 5'd9 },  // R6
    {3'd5, 3'd0, 5'd13, 1'b1, 5'd9 },  // R9 wrong id
    {3'd5, 3'd0, 5'd8,  1'b1, 5'd9 },  // R9 zero flag field
    {3'd5, 3'd0, 5'd9,  1'b0, 5'd0 }   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [2:0] ch, input logic [4:0] d);
    @(negedge clk);
    cfg_ch = ch; cfg_wdata = d[1:0]; pend_wdata = d;
    case (op)
      3'd0: evt_cmpl[ch] = 1'b1;
      3'd1: evt_err[ch] = 1'b1;
      3'd2: ien_set_we = 1'b1;
      3'd3: ien_clr_we = 1'b1;
      3'd4: flag_clr_we = 1'b1;
      3'd5: pend_we = 1'b1;
      default: begin evt_cmpl[ch] = 1'b1; flag_clr_we = 1'b1; end
    endcase
    @(negedge clk);
    evt_cmpl = '0; evt_err = '0;
    ien_set_we = 0; ien_clr_we = 0; flag_clr_we = 0; pend_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 irq", irq, 0);
    check("R1 pend", pend, 0);
    check("R1 flags", {fl_c, fl_e, en_c, en_e}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after release", irq, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][16:14], VEC[i][13:11], VEC[i][10:6]);
      repeat (2) @(negedge clk);
      check($sformatf("R8 vec%0d irq", i), irq, VEC[i][5]);
      check($sformatf("R8 vec%0d pend", i), pend, VEC[i][4:0]);
    end

    // R2: flag visible right after the edge that samples the pulse
    @(negedge clk); evt_err[7] = 1'b1;
    @(negedge clk); evt_err[7] = 1'b0;
    check("R2 err flag ch7", fl_e[7], 1);
    check("R10 irq with disabled flag", irq, 0);
    // R7: enable lands at edge k, irq at edge k+1
    @(negedge clk); cfg_ch = 3'd7; cfg_wdata = 2'b10; ien_set_we = 1'b1;
    @(negedge clk); ien_set_we = 1'b0;
    check("R3 err enable ch7", en_e[7], 1);
    check("R7 irq not yet", irq, 0);
    @(negedge clk);
    check("R7 irq one cycle later", irq, 1);
    check("R8 pend ch7 err", pend, {3'd7, 2'b10});

    // R4: set and clear of an enable in the same cycle, set wins
    @(negedge clk); cfg_ch = 3'd1; cfg_wdata = 2'b01; ien_set_we = 1'b1; ien_clr_we = 1'b1;
    @(negedge clk); ien_set_we = 1'b0; ien_clr_we = 1'b0;
    check("R4 set beats clear", en_c[1], 1);

    // R9: two channels pending, ack the lower, line stays high
    apply(3'd0, 3'd1, 5'd0);
    repeat (2) @(negedge clk);
    check("R8 lowest of two", pend, {3'd1, 2'b01});
    apply(3'd5, 3'd0, {3'd1, 2'b01});
    repeat (2) @(negedge clk);
    check("R9 irq stays high", irq, 1);
    check("R9 next channel reported", pend, {3'd7, 2'b10});
    check("R9 ch1 flag cleared", fl_c[1], 0);

    // R1: reset mid-run clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid-run reset", {irq, pend, fl_c, fl_e, en_c, en_e}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule